// File: doc/BRIEF.md
# Multicycle Accumulator Processor Sequencer

This block is a small processor that runs one instruction at a time as a fixed series of control steps. It keeps a program counter, a memory address register, a memory buffer register, an instruction register and one accumulator. It reaches a synchronous single-port word memory through an address bus, a read request, a write request, write data and read data. The memory returns read data one cycle after the request. The machine brings in an instruction word and decodes it. If the instruction asks for it, the machine runs an indirect step that reads the real operand address from memory. It then reads the operand, executes, and goes back for the next instruction.

The instruction set is deliberately small: load, store, add, shift-left-by-one, jump, halt. Each instruction that carries an address can name its target directly or through a pointer word in memory. A state output shows which control step is active in every cycle, so a bench can follow the exact sequence. The control unit drives the datapath only through a packed bundle of strobes.

Top module: `accCpu`

## Requirements
- R1: After reset the state output is FETCH (code 0) and halted is low. The first read request goes to byte address 0. The accumulator starts at zero, so an opening store writes 0.
- R2: State codes are FETCH=0, DECODE=1, INDIRECT=2, OPERAND=3, EXECUTE=4, HALTED=5. FETCH lasts three cycles, in this order: a cycle with no request while the counter is copied into the address register, a cycle with a read request, and a wait cycle. DECODE then lasts one cycle with no memory request.
- R3: The fetch read goes to the program counter. The counter advances by 4 (one 32-bit word in byte addressing) during that fetch.
- R4: An address-carrying instruction (load, store, add, jump) with its indirect flag set gets a two-cycle INDIRECT step: a read at the instruction's address field, then a wait. Only the low 24 bits of the returned word become the effective address; the upper bits are ignored.
- R5: Load and add get a two-cycle OPERAND step: a read at the effective address, then a wait. Store and jump make no operand read. Read and write requests are never raised together.
- R6: EXECUTE lasts one cycle. Load copies the operand into the accumulator. Add sums the operand into the accumulator, wrapping at 32 bits.
- R7: Store raises a write request for the single EXECUTE cycle. The address is the effective address and the data is the accumulator.
- R8: Jump puts the effective address into the program counter, which overrides the earlier increment. The next fetch reads from that address.
- R9: Shift-left (opcode 3) doubles the accumulator. Shift-left and undefined opcodes ignore the indirect flag, skip INDIRECT and OPERAND, and make no memory request. Undefined opcodes change nothing.
- R10: Halt (opcode 15) moves from DECODE to HALTED. Halted stays high, and no memory request is made, until reset. Reset brings the machine back to FETCH.
- R11: Instruction word layout: bits [31:28] opcode, bit 27 indirect flag, bits [23:0] byte address field. Opcodes: 0 load, 1 store, 2 add, 3 shift-left, 4 jump, 15 halt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| memAddr | output | 24 | Byte address to memory (from the address register) |
| memRdReq | output | 1 | Read request; data is due one cycle later |
| memWrReq | output | 1 | Write request for memWrData at memAddr |
| memWrData | output | 32 | Write data (the accumulator) |
| memRdData | input | 32 | Read data, valid the cycle after a read request |
| state | output | 3 | Current control step code |
| halted | output | 1 | High once a halt instruction has been decoded |

## Verification
Every memory read is answered in the cycle after its request. The buffer register takes that data at the end of the wait cycle, so a decode decision or an accumulator result shows up one or two steps after its read. The bench therefore keeps a behavioural interpreter that expands each instruction into its exact list of per-cycle expectations: the step code, the request lines, the address, and the write data. It compares that list against the ports at every falling edge, starting from the cycle in which reset is released. Values that are only visible through memory (the accumulator, the jump target) are checked in the store cycle that carries them. They are checked again in the bench memory once the program halts.

// File: rtl/accCpuPkg.sv
package accCpuPkg;

  typedef enum logic [2:0] {
    ST_FETCH    = 3'd0,
    ST_DECODE   = 3'd1,
    ST_INDIRECT = 3'd2,
    ST_OPERAND  = 3'd3,
    ST_EXECUTE  = 3'd4,
    ST_HALTED   = 3'd5
  } cpuState_e;

  localparam logic [3:0] OP_LOAD  = 4'd0;
  localparam logic [3:0] OP_STORE = 4'd1;
  localparam logic [3:0] OP_ADD   = 4'd2;
  localparam logic [3:0] OP_SHL   = 4'd3;
  localparam logic [3:0] OP_JUMP  = 4'd4;
  localparam logic [3:0] OP_HALT  = 4'd15;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic marFromPc;
    logic marFromMbr;
    logic marFromRd;
    logic pcInc;
    logic pcLoad;
    logic mbrLoad;
    logic irLoad;
    logic accLoad;
    logic accAdd;
    logic accShl;
    logic memRd;
    logic memWr;
  } ctrlStrobe_t;

  function automatic logic hasAddrField(logic [3:0] op);
    return (op == OP_LOAD) || (op == OP_STORE) || (op == OP_ADD) || (op == OP_JUMP);
  endfunction

  function automatic logic readsOperand(logic [3:0] op);
    return (op == OP_LOAD) || (op == OP_ADD);
  endfunction

endpackage

// File: rtl/accCtrl.sv
module accCtrl
  import accCpuPkg::*;
#(
  parameter int RD_LATENCY = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  mbrOp,
  input  logic        mbrInd,
  input  logic [3:0]  irOp,
  output ctrlStrobe_t stb,
  output cpuState_e   state
);

  localparam int FETCH_LAST = RD_LATENCY + 1;
  localparam int MEM_LAST   = RD_LATENCY;
  localparam int PHASE_W    = $clog2(FETCH_LAST + 1);

  logic [PHASE_W-1:0] phase, nextPhase;
  cpuState_e          nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_FETCH;
      phase <= '0;
    end else begin
      state <= nextState;
      phase <= nextPhase;
    end
  end

  always_comb begin
    stb       = '0;
    nextState = state;
    nextPhase = phase + 1'b1;
    case (state)
      ST_FETCH: begin
        if (phase == '0) stb.marFromPc = 1'b1;
        if (phase == PHASE_W'(1)) begin
          stb.memRd = 1'b1;
          stb.pcInc = 1'b1;
        end
        if (phase == PHASE_W'(FETCH_LAST)) begin
          stb.mbrLoad = 1'b1;
          nextState   = ST_DECODE;
          nextPhase   = '0;
        end
      end
      ST_DECODE: begin
        stb.irLoad     = 1'b1;
        stb.marFromMbr = 1'b1;
        nextPhase      = '0;
        if (mbrOp == OP_HALT)                      nextState = ST_HALTED;
        else if (hasAddrField(mbrOp) && mbrInd)    nextState = ST_INDIRECT;
        else if (readsOperand(mbrOp))              nextState = ST_OPERAND;
        else                                       nextState = ST_EXECUTE;
      end
      ST_INDIRECT: begin
        if (phase == '0) stb.memRd = 1'b1;
        if (phase == PHASE_W'(MEM_LAST)) begin
          stb.mbrLoad   = 1'b1;
          stb.marFromRd = 1'b1;
          nextPhase     = '0;
          nextState     = readsOperand(irOp) ? ST_OPERAND : ST_EXECUTE;
        end
      end
      ST_OPERAND: begin
        if (phase == '0) stb.memRd = 1'b1;
        if (phase == PHASE_W'(MEM_LAST)) begin
          stb.mbrLoad = 1'b1;
          nextPhase   = '0;
          nextState   = ST_EXECUTE;
        end
      end
      ST_EXECUTE: begin
        case (irOp)
          OP_LOAD:  stb.accLoad = 1'b1;
          OP_ADD:   stb.accAdd  = 1'b1;
          OP_SHL:   stb.accShl  = 1'b1;
          OP_STORE: stb.memWr   = 1'b1;
          OP_JUMP:  stb.pcLoad  = 1'b1;
          default:  ;
        endcase
        nextState = ST_FETCH;
        nextPhase = '0;
      end
      ST_HALTED: begin
        nextPhase = '0;
      end
      default: begin
        nextState = ST_FETCH;
        nextPhase = '0;
      end
    endcase
  end

  // R2
  decode_after_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DECODE) |-> ($past(state) == ST_FETCH));

  // R5
  no_rd_wr_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.memRd && stb.memWr));

  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HALTED) |=> (state == ST_HALTED));

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HALTED) |-> (!stb.memRd && !stb.memWr));

endmodule

// File: rtl/accDatapath.sv
module accDatapath
  import accCpuPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic [3:0]        mbrOp,
  output logic              mbrInd,
  output logic [3:0]        irOp
);

  localparam int OP_MSB  = DATA_W - 1;
  localparam int IND_BIT = DATA_W - 5;
  localparam int PC_STEP = DATA_W / 8;

  logic [ADDR_W-1:0] pc, mar;
  logic [DATA_W-1:0] mbr, ir, acc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc  <= '0;
      mar <= '0;
      mbr <= '0;
      ir  <= '0;
      acc <= '0;
    end else begin
      if (stb.marFromPc)       mar <= pc;
      else if (stb.marFromMbr) mar <= mbr[ADDR_W-1:0];
      else if (stb.marFromRd)  mar <= memRdData[ADDR_W-1:0];

      if (stb.pcInc)       pc <= pc + ADDR_W'(PC_STEP);
      else if (stb.pcLoad) pc <= mar;

      if (stb.mbrLoad) mbr <= memRdData;
      if (stb.irLoad)  ir  <= mbr;

      if (stb.accLoad)     acc <= mbr;
      else if (stb.accAdd) acc <= acc + mbr;
      else if (stb.accShl) acc <= {acc[DATA_W-2:0], 1'b0};
    end
  end

  assign memAddr   = mar;
  assign memWrData = acc;
  assign mbrOp     = mbr[OP_MSB -: 4];
  assign mbrInd    = mbr[IND_BIT];
  assign irOp      = ir[OP_MSB -: 4];

  logic unusedBits;
  assign unusedBits = ^{ir[IND_BIT:0], mbr[IND_BIT-1:ADDR_W]};

  // R3
  pc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.pcInc |=> (pc == $past(pc) + ADDR_W'(PC_STEP)));

  // R8
  jump_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.pcLoad |=> (pc == $past(mar)));

  // R4
  indirect_low_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.marFromRd |=> (memAddr == $past(memRdData[ADDR_W-1:0])));

  // R9
  shift_double_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.accShl |=> (memWrData == {$past(memWrData[DATA_W-2:0]), 1'b0}));

endmodule

// File: rtl/accCpu.sv
module accCpu
  import accCpuPkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 24,
  parameter int RD_LATENCY = 1
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdReq,
  output logic              memWrReq,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic [2:0]        state,
  output logic              halted
);

  ctrlStrobe_t stb;
  cpuState_e   ctrlState;
  logic [3:0]  mbrOp, irOp;
  logic        mbrInd;

  accCtrl #(.RD_LATENCY(RD_LATENCY)) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .mbrOp  (mbrOp),
    .mbrInd (mbrInd),
    .irOp   (irOp),
    .stb    (stb),
    .state  (ctrlState)
  );

  accDatapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .mbrOp     (mbrOp),
    .mbrInd    (mbrInd),
    .irOp      (irOp)
  );

  assign memRdReq = stb.memRd;
  assign memWrReq = stb.memWr;
  assign state    = ctrlState;
  assign halted   = (ctrlState == ST_HALTED);

endmodule

// File: tb/test_accCpu.sv
module test_accCpu;

  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 24;
  localparam int MEM_WORDS = 64;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rstN;
  logic [ADDR_W-1:0] memAddr;
  logic              memRdReq, memWrReq;
  logic [DATA_W-1:0] memWrData;
  logic [DATA_W-1:0] memRdData = '0;
  logic [2:0]        state;
  logic              halted;

  accCpu #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_accCpu (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memRdReq(memRdReq),
    .memWrReq(memWrReq), .memWrData(memWrData), .memRdData(memRdData),
    .state(state), .halted(halted)
  );

  // behavioural memory, one-cycle read latency
  logic [DATA_W-1:0] mem [MEM_WORDS];
  always @(posedge clk) begin
    if (memWrReq) mem[memAddr[7:2]] <= memWrData;
    if (memRdReq) memRdData <= mem[memAddr[7:2]];
  end

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [31:0] mm [MEM_WORDS];
  int qSt[$], qRd[$], qWr[$], qAddr[$], qData[$], qReq[$];

  function automatic string reqName(int r);
    case (r)
      1: return "R1";   2: return "R2";   3: return "R3";
      4: return "R4";   5: return "R5";   6: return "R6";
      7: return "R7";   8: return "R8";   9: return "R9";
      10: return "R10"; default: return "R11";
    endcase
  endfunction

  function automatic logic [31:0] enc(int op, int ind, int addr);
    logic [3:0]  o = op[3:0];
    logic        i = ind[0];
    logic [23:0] a = addr[23:0];
    return {o, i, 3'b000, a};
  endfunction

  task automatic put(int st, int rd, int wr, int addr, int data, int req);
    qSt.push_back(st); qRd.push_back(rd); qWr.push_back(wr);
    qAddr.push_back(addr); qData.push_back(data); qReq.push_back(req);
  endtask

  // Instruction-level interpreter expanded into per-cycle expectations
  task automatic buildModel();
    int pc = 0;
    logic [31:0] acc = '0;
    logic [31:0] irw, opv;
    int op, ind, fld, ea;
    for (int n = 0; n < 100; n++) begin
      put(0, 0, 0, 0, 0, (n == 0) ? 1 : 2);
      put(0, 1, 0, pc, 0, (n == 0) ? 1 : 3);
      put(0, 0, 0, 0, 0, 2);
      irw = mm[(pc >> 2) & 63];
      pc = (pc + 4) & 32'hFFFFFF;
      put(1, 0, 0, 0, 0, 2);
      op  = int'(irw[31:28]);
      ind = int'(irw[27]);
      fld = int'(irw[23:0]);
      if (op == 15) begin
        for (int h = 0; h < 12; h++) put(5, 0, 0, 0, 0, 10);
        break;
      end
      ea = fld;
      if ((op == 0 || op == 1 || op == 2 || op == 4) && ind == 1) begin
        put(2, 1, 0, fld, 0, 4);
        put(2, 0, 0, 0, 0, 4);
        ea = int'(mm[(fld >> 2) & 63] & 32'hFFFFFF);
      end
      opv = '0;
      if (op == 0 || op == 2) begin
        put(3, 1, 0, ea, 0, 5);
        put(3, 0, 0, 0, 0, 5);
        opv = mm[(ea >> 2) & 63];
      end
      case (op)
        0: begin acc = opv; put(4, 0, 0, 0, 0, 6); end
        2: begin acc = acc + opv; put(4, 0, 0, 0, 0, 6); end
        3: begin acc = acc << 1; put(4, 0, 0, 0, 0, 9); end
        1: begin put(4, 0, 1, ea, int'(acc), 7); mm[(ea >> 2) & 63] = acc; end
        4: begin pc = ea; put(4, 0, 0, 0, 0, 8); end
        default: put(4, 0, 0, 0, 0, 9);
      endcase
    end
  endtask

  task automatic runCycles();
    int cyc = 0;
    while (qSt.size() > 0) begin
      int st = qSt.pop_front();
      int rd = qRd.pop_front();
      int wr = qWr.pop_front();
      int ad = qAddr.pop_front();
      int da = qData.pop_front();
      int rq = qReq.pop_front();
      bit bad;
      bad = (state !== st[2:0]) || (halted !== (st == 5)) ||
            (memRdReq !== rd[0]) || (memWrReq !== wr[0]) ||
            (((rd | wr) != 0) && (memAddr !== ad[23:0])) ||
            ((wr != 0) && (memWrData !== da[31:0]));
      checks++;
      if (bad) begin
        errors++;
        $display("FAIL %s cycle %0d: got state=%0d halted=%0d rd=%0d wr=%0d addr=%h data=%h, expected state=%0d rd=%0d wr=%0d addr=%h data=%h",
                 reqName(rq), cyc, state, halted, memRdReq, memWrReq, memAddr, memWrData,
                 st, rd, wr, ad[23:0], da);
      end
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic checkWord(int idx, logic [31:0] exp, string tag);
    checks++;
    if (mem[idx] !== exp) begin
      errors++;
      $display("FAIL %s memory word %0d: got %h expected %h", tag, idx, mem[idx], exp);
    end
  endtask

  task automatic setWord(int idx, logic [31:0] w);
    mem[idx] = w;
    mm[idx]  = w;
  endtask

  task automatic clearMem();
    for (int i = 0; i < MEM_WORDS; i++) setWord(i, 32'h0);
  endtask

  initial begin
    rstN = 1'b0;
    // Program A: direct addressing, shift, jump, halt
    clearMem();
    setWord(32, 32'hFFFF_FFFF);
    setWord(33, 32'd5);
    setWord(34, 32'd7);
    setWord(36, 32'h1234_5678);
    setWord(0,  enc(1, 0, 'h80));
    setWord(1,  enc(0, 0, 'h84));
    setWord(2,  enc(2, 0, 'h88));
    setWord(3,  enc(3, 0, 0));
    setWord(4,  enc(1, 0, 'h8C));
    setWord(5,  enc(4, 0, 'h20));
    setWord(6,  enc(1, 0, 'h90));
    setWord(7,  enc(15, 0, 0));
    setWord(8,  enc(2, 0, 'h84));
    setWord(9,  enc(1, 0, 'h94));
    setWord(10, enc(15, 0, 0));
    buildModel();
    repeat (2) @(negedge clk);
    // R1: reset state
    checks++;
    if (state !== 3'd0 || halted !== 1'b0 || memRdReq !== 1'b0 || memWrReq !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: got state=%0d halted=%0d rd=%0d wr=%0d expected 0 0 0 0",
               state, halted, memRdReq, memWrReq);
    end
    rstN = 1'b1;
    runCycles();
    checkWord(32, 32'd0, "R1");
    checkWord(35, 32'd24, "R7");
    checkWord(36, 32'h1234_5678, "R8");
    checkWord(37, 32'd29, "R6");

    // Program B: indirect addressing, ignored flag, undefined opcode
    rstN = 1'b0;
    clearMem();
    setWord(33, 32'd5);
    setWord(34, 32'd7);
    setWord(40, 32'h0000_0084);
    setWord(41, 32'h0000_0030);
    setWord(42, 32'h0000_0098);
    setWord(43, 32'hFF00_0088);
    setWord(0,  enc(0, 1, 'hA0));
    setWord(1,  enc(2, 1, 'hA0));
    setWord(2,  enc(1, 1, 'hA8));
    setWord(3,  enc(4, 1, 'hA4));
    setWord(4,  enc(15, 0, 0));
    setWord(12, enc(3, 1, 'hA0));
    setWord(13, enc(1, 0, 'h9C));
    setWord(14, enc(7, 1, 'hA0));
    setWord(15, enc(0, 1, 'hAC));
    setWord(16, enc(1, 1, 'hA8));
    setWord(17, enc(15, 0, 0));
    buildModel();
    @(negedge clk);
    // R10: reset leaves the halted state
    checks++;
    if (state !== 3'd0 || halted !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset after halt: got state=%0d halted=%0d expected 0 0", state, halted);
    end
    rstN = 1'b1;
    runCycles();
    checkWord(38, 32'd7, "R4");
    checkWord(39, 32'd20, "R9");
    checkWord(40, 32'h0000_0084, "R11");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule